// File: doc/BRIEF.md
# Dual-Mask Priority Interrupt Controller

This block collects up to sixteen asynchronous interrupt lines, brings each one into the system clock domain, and latches every rising edge as a sticky pending bit. Of the lines that are both pending and enabled, the lowest-numbered one wins. The block presents a request to the processor core together with a vector, and the vector is the winning line's number.

Each line has two masks. The enable mask decides whether a pending line may raise the request and compete for the vector. The run mask decides whether accepting that line also pulses a wake output, which releases a halted core. When the core acknowledges, the pending bit of the line being presented is cleared, and the vector moves on to the next pending enabled line.

A small register port writes both masks and clears pending bits by writing ones. A combinational read port returns any of the three registers.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the pending bits, the enable mask and the run mask are all zero, and req_o and wake_o are low.
- R2: A rising edge on irq_raw_i[n] that is stable before clock edge k sets pending bit n at edge k+2, through a two-flop synchronizer and an edge detector. The input must stay stable for at least one clock.
- R3: Pending bits are set only by a rising edge, not by a level. A line held high does not set its bit again after that bit is cleared.
- R4: Priority is fixed, with line 0 highest. While req_o is high, vec_o (4 bits) equals the lowest index n whose pending bit and enable bit are both set.
- R5: req_o is high exactly when at least one line is both pending and enabled. A pending line whose enable bit is 0 stays pending but neither raises req_o nor wins vec_o.
- R6: When ack_i is high while req_o is high, the clock edge clears the pending bit of the line shown on vec_o. vec_o then shows the next winner in the following cycle. ack_i while req_o is low changes nothing.
- R7: wake_o is high for exactly the one cycle after an edge at which an acknowledge was accepted and the run-mask bit of the acknowledged line is 1. At all other times wake_o is low.
- R8: The register port uses wr_addr_i/rd_addr_i codes as follows: 0 is the enable mask, 1 is the run mask, and 2 is pending. A write to code 2 clears each pending bit where wr_data_i is 1 (write-one-to-clear). rd_data_o combinationally returns the addressed register, and returns zero for code 3.
- R9: When a line's rising edge is detected at the same edge that an acknowledge or a write-one-to-clear would clear its bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_raw_i | input | 16 | Asynchronous interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write select |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read select |
| rd_data_o | output | 16 | Register read data |
| ack_i | input | 1 | Core accepts the presented interrupt |
| req_o | output | 1 | Interrupt request to the core |
| vec_o | output | 4 | Vector address of the winning line |
| wake_o | output | 1 | Wake-from-halt pulse |

## Verification
A raw edge reaches the pending bits, req_o and vec_o two edges after it is sampled. Acknowledges and register writes change pending bits and vec_o at the very next edge. wake_o is registered, so it rises one edge after the accepted acknowledge, and rd_data_o follows rd_addr_i within the same cycle. The bench steps a behavioural model at each rising edge, using a queue of past raw samples to reproduce the synchronizer delay, and compares every output at the following falling edge. Directed sequences check the two-edge latency and the set-wins-over-clear case with hand-counted timing.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_RUN  = 2'd1,
    REG_PEND = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned NUM_LINES   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] raw_i,
  output logic [NUM_LINES-1:0] rise_o
);
  logic [NUM_LINES-1:0] stage_q [SYNC_STAGES];
  logic [NUM_LINES-1:0] prev_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= raw_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= stage_q[SYNC_STAGES-1];
  end

  assign rise_o = stage_q[SYNC_STAGES-1] & ~prev_q;

  // edge seen now was present at the raw input two edges back
  p_sync_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |-> (($past(raw_i, 2) & rise_o) == rise_o));
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] set_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else pend_q <= (pend_q & ~clr_i) | set_i; // set wins
  end

  assign pend_o = pend_q;

  p_set_sticks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));
  p_no_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_addr_i,
  input  logic [NUM_LINES-1:0] wr_data_i,
  output logic [NUM_LINES-1:0] en_mask_o,
  output logic [NUM_LINES-1:0] run_mask_o,
  output logic [NUM_LINES-1:0] pend_clr_o
);
  logic [NUM_LINES-1:0] en_q, run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      run_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == REG_EN)  en_q  <= wr_data_i;
      if (wr_addr_i == REG_RUN) run_q <= wr_data_i;
    end
  end

  assign en_mask_o  = en_q;
  assign run_mask_o = run_q;
  assign pend_clr_o = (wr_en_i && wr_addr_i == REG_PEND) ? wr_data_i : '0;

  p_mask_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(en_q) && $stable(run_q)));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned VEC_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] cand_i,
  output logic                 any_o,
  output logic [VEC_W-1:0]     idx_o
);
  localparam logic [NUM_LINES-1:0] ONE = NUM_LINES'(1);

  always_comb begin
    idx_o = '0;
    for (int i = NUM_LINES-1; i >= 0; i--) begin
      if (cand_i[i]) idx_o = VEC_W'(i);
    end
  end

  assign any_o = |cand_i;

  always_comb begin
    if (any_o) begin
      p_lowest_wins_r4: assert (cand_i[idx_o] &&
        ((cand_i & ((ONE << idx_o) - ONE)) == '0));
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned VEC_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_raw_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_addr_i,
  input  logic [NUM_LINES-1:0] wr_data_i,
  input  logic [1:0]           rd_addr_i,
  output logic [NUM_LINES-1:0] rd_data_o,
  input  logic                 ack_i,
  output logic                 req_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 wake_o
);
  localparam logic [NUM_LINES-1:0] ONE = NUM_LINES'(1);

  logic [NUM_LINES-1:0] rise, pend, en_mask, run_mask, wr_clr, ack_clr;
  logic                 ack_take, wake_q;

  irq_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .raw_i(irq_raw_i), .rise_o(rise)
  );

  irq_mask_regs #(.NUM_LINES(NUM_LINES)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_mask_o(en_mask), .run_mask_o(run_mask), .pend_clr_o(wr_clr)
  );

  irq_pending #(.NUM_LINES(NUM_LINES)) i_pend (
    .clk_i, .rst_ni, .set_i(rise), .clr_i(wr_clr | ack_clr), .pend_o(pend)
  );

  irq_prio_enc #(.NUM_LINES(NUM_LINES)) i_enc (
    .cand_i(pend & en_mask), .any_o(req_o), .idx_o(vec_o)
  );

  assign ack_take = ack_i & req_o;
  assign ack_clr  = ack_take ? (ONE << vec_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else wake_q <= ack_take & run_mask[vec_o];
  end
  assign wake_o = wake_q;

  always_comb begin
    case (reg_sel_e'(rd_addr_i))
      REG_EN:   rd_data_o = en_mask;
      REG_RUN:  rd_data_o = run_mask;
      REG_PEND: rd_data_o = pend;
      default:  rd_data_o = '0;
    endcase
  end

  p_req_has_winner_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (pend[vec_o] && en_mask[vec_o]));
  p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_take && !rise[vec_o]) |=> !pend[$past(vec_o)]);
  p_wake_after_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(ack_take && run_mask[vec_o]));
  p_wake_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_take |=> !wake_o);
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_raw = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [N-1:0]  wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [N-1:0]  rd_data;
  logic          ack = 1'b0;
  logic          req;
  logic [3:0]    vec;
  logic          wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_raw_i(irq_raw), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .ack_i(ack), .req_o(req), .vec_o(vec), .wake_o(wake)
  );

  // behavioural reference
  logic [N-1:0] hist[$];
  logic [N-1:0] m_pend, m_en, m_run;
  logic         m_wake;

  function automatic int winner(logic [N-1:0] p, logic [N-1:0] e);
    for (int i = 0; i < N; i++) if (p[i] && e[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{16'h0, 16'h0, 16'h0};
      m_pend = '0; m_en = '0; m_run = '0; m_wake = 1'b0;
    end else begin
      automatic logic [N-1:0] rise = hist[1] & ~hist[2];
      automatic logic [N-1:0] clr = '0;
      automatic int w = winner(m_pend, m_en);
      m_wake = 1'b0;
      if (ack && w >= 0) begin
        clr[w] = 1'b1;
        m_wake = m_run[w];
      end
      if (wr_en && wr_addr == 2'd2) clr = clr | wr_data;
      m_pend = (m_pend & ~clr) | rise;
      if (wr_en && wr_addr == 2'd0) m_en = wr_data;
      if (wr_en && wr_addr == 2'd1) m_run = wr_data;
      hist.push_front(irq_raw);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic int w = winner(m_pend, m_en);
      automatic logic [N-1:0] rd_exp;
      chk("R5 req", int'(req), int'(w >= 0));
      if (w >= 0) chk("R4 vec", int'(vec), w);
      chk("R7 wake", int'(wake), int'(m_wake));
      case (rd_addr)
        2'd0: rd_exp = m_en;
        2'd1: rd_exp = m_run;
        2'd2: rd_exp = m_pend;
        default: rd_exp = '0;
      endcase
      chk("R8 rd_data", int'(rd_data), int'(rd_exp));
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 req", int'(req), 0);
    chk("R1 wake", int'(wake), 0);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1 chk("R1 regs", int'(rd_data), 0);
    end
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0080);
    // R2 latency: drive before edge k, pending at k+2
    irq_raw[5] = 1'b1;
    step(); chk("R2 early1", int'(req), 0);
    step(); chk("R2 early2", int'(req), 0);
    step(); chk("R2 due", int'(req), 1);
    chk("R2 vec", int'(vec), 5);
    // R4 priority among 2, 5, 7
    irq_raw[7] = 1'b1; irq_raw[2] = 1'b1;
    step(3);
    chk("R4 prio", int'(vec), 2);
    // R5 disabled line loses but stays pending
    wr(2'd0, 16'hFFFB);
    chk("R5 masked", int'(vec), 5);
    rd_addr = 2'd2;
    #1 chk("R5 still pending", int'(rd_data[2]), 1);
    wr(2'd0, 16'hFFFF);
    // R6/R7 ack of line 2 (run bit 0)
    ack = 1'b1; step(); ack = 1'b0;
    chk("R6 next", int'(vec), 5);
    chk("R7 no wake", int'(wake), 0);
    ack = 1'b1; step(); ack = 1'b0;
    chk("R6 next2", int'(vec), 7);
    ack = 1'b1; step(); ack = 1'b0;
    chk("R7 wake", int'(wake), 1);
    chk("R6 empty", int'(req), 0);
    step();
    chk("R7 one cycle", int'(wake), 0);
    // R3 held level does not re-set
    step(4);
    chk("R3 level", int'(req), 0);
    // R6 ack without req ignored
    ack = 1'b1; step(); ack = 1'b0;
    chk("R6 idle ack", int'(wake), 0);
    // R9 set wins over W1C
    irq_raw = '0; step(4);
    irq_raw[3] = 1'b1; step(2);
    chk("R9 pre", int'(req), 0);
    wr(2'd2, 16'h0008);
    chk("R9 set wins", int'(rd_data[3]), 1);
    // R8 W1C clears
    wr(2'd2, 16'h0008);
    chk("R8 w1c", int'(rd_data[3]), 0);
    rd_addr = 2'd3;
    #1 chk("R8 code3", int'(rd_data), 0);
    // random traffic
    for (int c = 0; c < 5000; c++) begin
      if ($urandom_range(3) == 0) irq_raw = irq_raw ^ N'(1 << $urandom_range(N-1));
      ack = ($urandom_range(3) == 0);
      wr_en = ($urandom_range(9) == 0);
      wr_addr = 2'($urandom_range(3));
      wr_data = N'($urandom);
      rd_addr = 2'($urandom_range(3));
      step();
    end
    wr_en = 1'b0; ack = 1'b0;
    step();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule